// File: doc/BRIEF.md
# DDR Command Slot Word Builder

This block turns one DDR3 command per slow-clock load into the parallel words that feed the 4:1 output serializers on the command and address pins. Each load takes the active-low RAS#, CAS# and WE# levels, the CS#, CKE and ODT levels, a row or column address, a bank number and a slot select. The slot select chooses which of the four serial bit times carries the command. The RAS#, CAS# and WE# levels go into that one position, and the other three positions are filled with the NOP level, which is high.

The address, bank, CS#, CKE and ODT bits are not slotted. Each of these bits is copied into all four positions of its word. Every output word is registered on the slow clock.

The slot can change from one word to the next. A controller can therefore meet a five-DDR-clock spacing between commands by moving the second command to a later position in the next word, instead of skipping a whole word. The serializer primitives, IO delays and pad drivers sit outside this block.

Top module: `ddr_slot_word_builder`

## Requirements
- R1: While reset is asserted, the RAS#, CAS#, WE# and CS# words read all ones. The CKE, ODT, address and bank words read all zeros.
- R2: After a load, each of the RAS#, CAS# and WE# words is high in every bit position except the selected slot.
- R3: After a load, the bit whose index equals the slot select holds the requested RAS#, CAS# or WE# level. Bit 0 is the first bit the serializer sends and bit 3 is the last.
- R4: Address bit k occupies word bits [4k+3:4k], and bank bit k occupies the same range in the bank word. All four positions carry that input bit's value, whatever the slot select is.
- R5: The CS#, CKE and ODT words each carry their input level in all four positions, whatever the slot select is.
- R6: The output words change only on a clock edge with `load_en` high, and take that edge's inputs. With `load_en` low they hold their values while the inputs change.
- R7: The slot select may differ on every consecutive load, and each word reflects only its own slot select.
- R8: A command loaded in slot a, followed by a command in slot b on the next load, appears on the pin 4 + b - a DDR clocks later. The case a = 0, b = 1 gives the five-clock spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow serializer load clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_en | input | 1 | Captures the inputs into the output words on this edge |
| slot_sel | input | SLOT_W | Bit position that carries the command |
| ras_n_in | input | 1 | Requested RAS# level |
| cas_n_in | input | 1 | Requested CAS# level |
| we_n_in | input | 1 | Requested WE# level |
| cs_n_in | input | 1 | Chip select level, replicated |
| cke_in | input | 1 | Clock enable level, replicated |
| odt_in | input | 1 | On-die termination level, replicated |
| addr_in | input | ADDR_W | Row or column address |
| bank_in | input | BANK_W | Bank number |
| ras_n_word | output | SER_RATIO | RAS# serializer word |
| cas_n_word | output | SER_RATIO | CAS# serializer word |
| we_n_word | output | SER_RATIO | WE# serializer word |
| cs_n_word | output | SER_RATIO | CS# serializer word |
| cke_word | output | SER_RATIO | CKE serializer word |
| odt_word | output | SER_RATIO | ODT serializer word |
| addr_word | output | ADDR_W*SER_RATIO | Address words, SER_RATIO bits per address bit |
| bank_word | output | BANK_W*SER_RATIO | Bank words, SER_RATIO bits per bank bit |

## Verification
The bench builds the block with ADDR_W = 4, BANK_W = 2 and SER_RATIO = 4. With these values it can sweep all four slots against all eight RAS#/CAS#/WE# combinations and a set of address patterns. Every address and bank bit is seen at both levels within that sweep. The narrow configuration also makes it cheap to check pairs of back-to-back loads with different slots, and to measure the pin-level spacing between two commands directly from the captured words.

// File: rtl/ddr_slot_pkg.sv
package ddr_slot_pkg;

  // NOP level for the active-low command strobes.
  localparam logic STROBE_IDLE = 1'b1;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  typedef struct packed {
    logic cs_n;
    logic cke;
    logic odt;
  } level_t;

endpackage

// File: rtl/ddr_rst_sync.sv
module ddr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/ddr_slot_decode.sv
module ddr_slot_decode #(
  parameter int SER_RATIO = 4,
  localparam int SLOT_W = $clog2(SER_RATIO)
) (
  input  logic [SLOT_W-1:0]    slot_sel,
  output logic [SER_RATIO-1:0] slot_hot
);
  for (genvar p = 0; p < SER_RATIO; p++) begin : g_pos
    assign slot_hot[p] = (slot_sel == SLOT_W'(p));
  end
endmodule

// File: rtl/ddr_strobe_lane.sv
module ddr_strobe_lane #(
  parameter int SER_RATIO = 4
) (
  input  logic                 level,
  input  logic [SER_RATIO-1:0] slot_hot,
  output logic [SER_RATIO-1:0] word
);
  import ddr_slot_pkg::*;
  for (genvar p = 0; p < SER_RATIO; p++) begin : g_pos
    assign word[p] = slot_hot[p] ? level : STROBE_IDLE;
  end
endmodule

// File: rtl/ddr_repl_lane.sv
module ddr_repl_lane #(
  parameter int WIDTH     = 1,
  parameter int SER_RATIO = 4
) (
  input  logic [WIDTH-1:0]           bits,
  output logic [WIDTH*SER_RATIO-1:0] words
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign words[k*SER_RATIO +: SER_RATIO] = {SER_RATIO{bits[k]}};
  end
endmodule

// File: rtl/ddr_word_reg.sv
module ddr_word_reg #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_next;
  end
endmodule

// File: rtl/ddr_slot_word_builder.sv
module ddr_slot_word_builder #(
  parameter int ADDR_W    = 14,
  parameter int BANK_W    = 3,
  parameter int SER_RATIO = 4,
  localparam int SLOT_W   = $clog2(SER_RATIO)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_en,
  input  logic [SLOT_W-1:0]           slot_sel,
  input  logic                        ras_n_in,
  input  logic                        cas_n_in,
  input  logic                        we_n_in,
  input  logic                        cs_n_in,
  input  logic                        cke_in,
  input  logic                        odt_in,
  input  logic [ADDR_W-1:0]           addr_in,
  input  logic [BANK_W-1:0]           bank_in,
  output logic [SER_RATIO-1:0]        ras_n_word,
  output logic [SER_RATIO-1:0]        cas_n_word,
  output logic [SER_RATIO-1:0]        we_n_word,
  output logic [SER_RATIO-1:0]        cs_n_word,
  output logic [SER_RATIO-1:0]        cke_word,
  output logic [SER_RATIO-1:0]        odt_word,
  output logic [ADDR_W*SER_RATIO-1:0] addr_word,
  output logic [BANK_W*SER_RATIO-1:0] bank_word
);
  import ddr_slot_pkg::*;

  localparam int STROBES = $bits(strobe_t);
  localparam int LEVELS  = $bits(level_t);
  localparam int STR_W   = STROBES * SER_RATIO;
  localparam int LVL_W   = LEVELS * SER_RATIO;
  localparam int AW      = ADDR_W * SER_RATIO;
  localparam int BW      = BANK_W * SER_RATIO;

  logic rst_core_n;

  ddr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  logic [SER_RATIO-1:0] slot_hot;

  ddr_slot_decode #(.SER_RATIO(SER_RATIO)) u_dec (
    .slot_sel (slot_sel),
    .slot_hot (slot_hot)
  );

  // Strobe lanes: command level in the chosen position, NOP elsewhere.
  strobe_t            strobe_in;
  logic [STROBES-1:0] strobe_bits;
  logic [STR_W-1:0]   strobe_d;
  logic [STR_W-1:0]   strobe_q;

  always_comb begin
    strobe_in.ras_n = ras_n_in;
    strobe_in.cas_n = cas_n_in;
    strobe_in.we_n  = we_n_in;
    strobe_bits     = strobe_in;
  end

  for (genvar s = 0; s < STROBES; s++) begin : g_strobe
    ddr_strobe_lane #(.SER_RATIO(SER_RATIO)) u_lane (
      .level    (strobe_bits[s]),
      .slot_hot (slot_hot),
      .word     (strobe_d[s*SER_RATIO +: SER_RATIO])
    );
  end

  // Level lanes and address/bank: replicated into every position.
  level_t            level_in;
  logic [LEVELS-1:0] level_bits;
  logic [LVL_W-1:0]  level_d;
  logic [LVL_W-1:0]  level_q;
  logic [AW-1:0]     addr_d;
  logic [BW-1:0]     bank_d;

  always_comb begin
    level_in.cs_n = cs_n_in;
    level_in.cke  = cke_in;
    level_in.odt  = odt_in;
    level_bits    = level_in;
  end

  ddr_repl_lane #(.WIDTH(LEVELS), .SER_RATIO(SER_RATIO)) u_lvl (
    .bits  (level_bits),
    .words (level_d)
  );

  ddr_repl_lane #(.WIDTH(ADDR_W), .SER_RATIO(SER_RATIO)) u_addr (
    .bits  (addr_in),
    .words (addr_d)
  );

  ddr_repl_lane #(.WIDTH(BANK_W), .SER_RATIO(SER_RATIO)) u_bank (
    .bits  (bank_in),
    .words (bank_d)
  );

  // Registered outputs.
  // Level layout is {cs_n, cke, odt} from MSB, so only the cs_n word resets high.
  localparam logic [LVL_W-1:0] LVL_RST =
    {{SER_RATIO{1'b1}}, {(LVL_W-SER_RATIO){1'b0}}};

  ddr_word_reg #(.W(STR_W), .RST_VAL({STR_W{1'b1}})) u_strobe_reg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (load_en),
    .d     (strobe_d),
    .q     (strobe_q)
  );

  ddr_word_reg #(.W(LVL_W), .RST_VAL(LVL_RST)) u_level_reg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (load_en),
    .d     (level_d),
    .q     (level_q)
  );

  ddr_word_reg #(.W(AW), .RST_VAL('0)) u_addr_reg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (load_en),
    .d     (addr_d),
    .q     (addr_word)
  );

  ddr_word_reg #(.W(BW), .RST_VAL('0)) u_bank_reg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (load_en),
    .d     (bank_d),
    .q     (bank_word)
  );

  // Strobe packing follows strobe_t, MSB first: ras_n, cas_n, we_n.
  assign ras_n_word = strobe_q[2*SER_RATIO +: SER_RATIO];
  assign cas_n_word = strobe_q[1*SER_RATIO +: SER_RATIO];
  assign we_n_word  = strobe_q[0*SER_RATIO +: SER_RATIO];
  assign cs_n_word  = level_q[2*SER_RATIO +: SER_RATIO];
  assign cke_word   = level_q[1*SER_RATIO +: SER_RATIO];
  assign odt_word   = level_q[0*SER_RATIO +: SER_RATIO];
endmodule

// File: rtl/ddr_slot_word_builder_chk.sv
module ddr_slot_word_builder_chk #(
  parameter int ADDR_W    = 14,
  parameter int BANK_W    = 3,
  parameter int SER_RATIO = 4,
  localparam int SLOT_W   = $clog2(SER_RATIO)
) (
  input logic                        clk,
  input logic                        rst_core_n,
  input logic                        load_en,
  input logic [SLOT_W-1:0]           slot_sel,
  input logic                        ras_n_in,
  input logic                        cke_in,
  input logic [ADDR_W-1:0]           addr_in,
  input logic [SER_RATIO-1:0]        ras_n_word,
  input logic [SER_RATIO-1:0]        cas_n_word,
  input logic [SER_RATIO-1:0]        we_n_word,
  input logic [SER_RATIO-1:0]        cke_word,
  input logic [ADDR_W*SER_RATIO-1:0] addr_word,
  input logic [BANK_W*SER_RATIO-1:0] bank_word
);
  // Goes high one edge after the core reset releases, so $past is valid.
  logic past_ok;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) past_ok <= 1'b0;
    else             past_ok <= 1'b1;
  end

  // R2: at most one position of any strobe word is low.
  p_nop_fill_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($countones(ras_n_word & cas_n_word & we_n_word) >= SER_RATIO - 1));

  // R3: the loaded slot position carries the requested RAS# level.
  p_slot_place_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (past_ok && $past(load_en)) |-> (ras_n_word[$past(slot_sel)] == $past(ras_n_in)));

  // R5: CKE follows its input across all positions.
  p_cke_repl_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (past_ok && $past(load_en)) |-> (cke_word == {SER_RATIO{$past(cke_in)}}));

  // R6: no load, no change.
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (past_ok && !$past(load_en)) |->
      ($stable(ras_n_word) && $stable(addr_word) && $stable(bank_word)));

  // R4: every address/bank word is uniform, and address follows its input.
  for (genvar k = 0; k < ADDR_W; k++) begin : g_addr
    p_addr_repl_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
      (past_ok && $past(load_en)) |->
        (addr_word[k*SER_RATIO +: SER_RATIO] == {SER_RATIO{$past(addr_in[k])}}));
  end
  for (genvar k = 0; k < BANK_W; k++) begin : g_bank
    p_bank_uniform_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
      (bank_word[k*SER_RATIO +: SER_RATIO] == '0) ||
      (bank_word[k*SER_RATIO +: SER_RATIO] == '1));
  end
endmodule

bind ddr_slot_word_builder ddr_slot_word_builder_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .SER_RATIO(SER_RATIO)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .load_en    (load_en),
  .slot_sel   (slot_sel),
  .ras_n_in   (ras_n_in),
  .cke_in     (cke_in),
  .addr_in    (addr_in),
  .ras_n_word (ras_n_word),
  .cas_n_word (cas_n_word),
  .we_n_word  (we_n_word),
  .cke_word   (cke_word),
  .addr_word  (addr_word),
  .bank_word  (bank_word)
);

// File: tb/ddr_slot_word_builder_test.sv
module ddr_slot_word_builder_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 4;
  localparam int BW  = 2;
  localparam int SER = 4;
  localparam int SW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic [SW-1:0] slot_sel = '0;
  logic ras_n_in = 1'b1, cas_n_in = 1'b1, we_n_in = 1'b1;
  logic cs_n_in = 1'b1, cke_in = 1'b0, odt_in = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [BW-1:0] bank_in = '0;
  logic [SER-1:0] ras_n_word, cas_n_word, we_n_word, cs_n_word, cke_word, odt_word;
  logic [AW*SER-1:0] addr_word;
  logic [BW*SER-1:0] bank_word;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_slot_word_builder #(.ADDR_W(AW), .BANK_W(BW), .SER_RATIO(SER)) uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .slot_sel(slot_sel),
    .ras_n_in(ras_n_in), .cas_n_in(cas_n_in), .we_n_in(we_n_in),
    .cs_n_in(cs_n_in), .cke_in(cke_in), .odt_in(odt_in),
    .addr_in(addr_in), .bank_in(bank_in),
    .ras_n_word(ras_n_word), .cas_n_word(cas_n_word), .we_n_word(we_n_word),
    .cs_n_word(cs_n_word), .cke_word(cke_word), .odt_word(odt_word),
    .addr_word(addr_word), .bank_word(bank_word)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected strobe word: NOP everywhere, requested level at the slot.
  function automatic logic [SER-1:0] strobe_exp(input int slot, input logic lvl);
    logic [SER-1:0] w = '1;
    w[slot] = lvl;
    return w;
  endfunction

  function automatic logic [31:0] repl_exp(input logic [31:0] v, input int width);
    logic [31:0] r = '0;
    for (int k = 0; k < width; k++)
      for (int p = 0; p < SER; p++) r[k*SER+p] = v[k];
    return r;
  endfunction

  task automatic drive(input int slot, input logic [2:0] cmd, input logic [2:0] lvl,
                       input logic [AW-1:0] a, input logic [BW-1:0] b);
    slot_sel = SW'(slot);
    {ras_n_in, cas_n_in, we_n_in} = cmd;
    {cs_n_in, cke_in, odt_in} = lvl;
    addr_in = a;
    bank_in = b;
  endtask

  task automatic check_all(input int slot, input logic [2:0] cmd, input logic [2:0] lvl,
                           input logic [AW-1:0] a, input logic [BW-1:0] b);
    chk("R2/R3", "ras_n_word", 32'(ras_n_word), 32'(strobe_exp(slot, cmd[2])));
    chk("R2/R3", "cas_n_word", 32'(cas_n_word), 32'(strobe_exp(slot, cmd[1])));
    chk("R2/R3", "we_n_word",  32'(we_n_word),  32'(strobe_exp(slot, cmd[0])));
    chk("R5", "cs_n_word", 32'(cs_n_word), repl_exp(32'(lvl[2]), 1));
    chk("R5", "cke_word",  32'(cke_word),  repl_exp(32'(lvl[1]), 1));
    chk("R5", "odt_word",  32'(odt_word),  repl_exp(32'(lvl[0]), 1));
    chk("R4", "addr_word", 32'(addr_word), repl_exp(32'(a), AW));
    chk("R4", "bank_word", 32'(bank_word), repl_exp(32'(b), BW));
  endtask

  function automatic int low_pos(input logic [SER-1:0] w);
    for (int p = 0; p < SER; p++) if (!w[p]) return p;
    return -1;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, seen while reset is held.
    repeat (3) @(negedge clk);
    chk("R1", "ras_n_word", 32'(ras_n_word), 32'hF);
    chk("R1", "cas_n_word", 32'(cas_n_word), 32'hF);
    chk("R1", "we_n_word",  32'(we_n_word),  32'hF);
    chk("R1", "cs_n_word",  32'(cs_n_word),  32'hF);
    chk("R1", "cke/odt",    32'({cke_word, odt_word}), 32'h0);
    chk("R1", "addr/bank",  32'({addr_word, bank_word}), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Exhaustive sweep: slot x strobe levels x address patterns (R2 R3 R4 R5 R7).
    for (int s = 0; s < SER; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int pat = 0; pat < 4; pat++) begin
          logic [AW-1:0] a;
          logic [BW-1:0] b;
          logic [2:0] l;
          a = AW'((c * 5 + pat * 3 + s) % 16);
          b = BW'(pat ^ s);
          l = 3'((c + pat) % 8);
          drive(s, 3'(c), l, a, b);
          load_en = 1'b1;
          @(negedge clk);
          check_all(s, 3'(c), l, a, b);
        end
      end
    end

    // R7: slot changes on every consecutive load.
    for (int i = 0; i < 16; i++) begin
      int s;
      s = (i * 3 + 1) % SER;
      drive(s, 3'b010, 3'b010, AW'(i), BW'(i));
      load_en = 1'b1;
      @(negedge clk);
      chk("R7", "ras_n_word", 32'(ras_n_word), 32'(strobe_exp(s, 1'b0)));
      chk("R7", "we_n_word",  32'(we_n_word),  32'(strobe_exp(s, 1'b0)));
    end

    // R6: hold with load_en low while inputs change.
    drive(2, 3'b011, 3'b110, 4'hA, 2'h1);
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      drive(i, 3'(i + 4), 3'(i), AW'(i * 7), BW'(3 - i));
      @(negedge clk);
      check_all(2, 3'b011, 3'b110, 4'hA, 2'h1);
    end
    load_en = 1'b1;
    @(negedge clk);
    check_all(3, 3'b111, 3'b011, AW'(21), BW'(0));

    // R8: pin spacing between commands in consecutive words.
    for (int a = 0; a < SER; a++) begin
      for (int b = 0; b < SER; b++) begin
        logic [SER-1:0] w0, w1;
        drive(a, 3'b011, 3'b010, '0, '0);
        load_en = 1'b1;
        @(negedge clk);
        w0 = ras_n_word;
        drive(b, 3'b011, 3'b010, '0, '0);
        @(negedge clk);
        w1 = ras_n_word;
        chk("R8", "spacing", 32'(SER + low_pos(w1) - low_pos(w0)), 32'(SER + b - a));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule